// File: doc/BRIEF.md
# Reset cause capture register

This block is an 8-bit status register. It records which event caused the most recent reset, so that start-up software can choose its recovery path. A reset controller delivers one-cycle pulses, one for each reset source: power-on, the external hardware pin, voltage monitors 0, 1 and 2, oscillator-stop detection, the watchdog, and a software request. The block keeps one flag for each of the causes that software needs to tell apart. It also keeps a cold/warm start flag, which software sets once it has initialised and which only power-on clears.

The flags sit in storage that the general system reset does not clear. A reset pulse updates them in the clock edge that samples it, so the values are ready to read once the reset ends. The bus side is a plain register port. Address decode happens elsewhere and the block receives a select. A write strobe and a byte of write data carry the writes, and a registered read data output returns the value. Each bit applies its own write rule: one bit can only be set by software, one can only be cleared by software, and the rest are read-only.

Top module: `rst_cause_reg`

## Requirements
- R1: While `sel`=1 and `wr_en`=0 at a clock edge, `rd_data` shows the register value after that edge and holds it until the next edge. When `sel` is 0 or `wr_en` is 1, `rd_data` becomes 0x00 at that edge. The layout is: bit 0 cold/warm start (1 = warm start), bit 1 hardware pin reset, bit 2 software reset, bit 3 watchdog reset, bit 4 voltage monitor 1 reset, bit 5 voltage monitor 2 reset, bit 6 oscillator-stop reset. Bit 7 always reads 0.
- R2: A power-on pulse clears all seven flags to 0 at the edge that samples it.
- R3: A voltage monitor 0 pulse clears bits 1 to 6 and leaves bit 0 unchanged.
- R4: Each of the other reset pulses has its own result, and all of them leave bit 0 unchanged:
  - voltage monitor 1, voltage monitor 2, watchdog, software and hardware pin each set their own flag, clear the other flags among bits 1 to 5, and leave bit 6 unchanged;
  - an oscillator-stop pulse sets bit 6 and clears bits 1 to 5.
- R5: When several pulses arrive in the same cycle, only the highest-priority one takes effect. The order from highest to lowest is: power-on, voltage monitor 0, voltage monitor 1, voltage monitor 2, oscillator stop, watchdog, software, hardware pin.
- R6: A write with data bit 0 = 1 sets bit 0. A write with data bit 0 = 0 leaves bit 0 unchanged.
- R7: A write with data bit 6 = 0 clears bit 6. A write with data bit 6 = 1 leaves bit 6 unchanged.
- R8: Writes have no effect on bits 1 to 5 or on bit 7.
- R9: `rst_n` low does not change the flags. It clears `rd_data` to 0x00 at each edge while it is low.
- R10: A write in the same cycle as any reset pulse is discarded. The pulse result of R2 to R5 applies instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | General system reset, synchronous, active low; clears only the read path |
| pls_por | input | 1 | Power-on reset pulse |
| pls_pin | input | 1 | External hardware pin reset pulse |
| pls_vm0 | input | 1 | Voltage monitor 0 reset pulse |
| pls_vm1 | input | 1 | Voltage monitor 1 reset pulse |
| pls_vm2 | input | 1 | Voltage monitor 2 reset pulse |
| pls_osc | input | 1 | Oscillator-stop reset pulse |
| pls_wdt | input | 1 | Watchdog reset pulse |
| pls_sw | input | 1 | Software reset request pulse |
| sel | input | 1 | Register selected by the external address decode |
| wr_en | input | 1 | Write strobe, qualified by `sel` |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |

## Verification
A pulse or a write changes the flags at the first rising edge that samples it. A read that starts at the next falling edge captures the new value at the following edge, so each result is sampled at the falling edge two edges after the stimulus was driven. The bench drives every input at a falling edge, waits exactly that many edges, and compares `rd_data` at a falling edge against a byte model written from the requirements. It sweeps all 256 pulse combinations and all 256 write bytes from several starting states.

// File: rtl/rcr_pkg.sv
// Package: rcr_pkg
// Shared widths and source indices for the reset cause register.
// The source index order is also the priority order: index 0 is the highest.
package rcr_pkg;
    localparam int REG_W = 8;            // bus byte width
    localparam int FLG_W = 7;            // stored flags, bits 0..6
    localparam int SRC_N = 8;            // number of reset sources

    // Source indices, highest priority first.
    localparam int S_POR = 0;
    localparam int S_VM0 = 1;
    localparam int S_VM1 = 2;
    localparam int S_VM2 = 3;
    localparam int S_OSC = 4;
    localparam int S_WDT = 5;
    localparam int S_SW  = 6;
    localparam int S_PIN = 7;

    // Register bit positions.
    localparam int B_CWS = 0;
    localparam int B_OSC = 6;
    localparam int B_RO_LO = 1;
    localparam int B_RO_HI = 5;

    // Which source owns a read-only cause flag bit (bits 1..5).
    function automatic int owner_of(input int bitpos);
        case (bitpos)
            1:       owner_of = S_PIN;
            2:       owner_of = S_SW;
            3:       owner_of = S_WDT;
            4:       owner_of = S_VM1;
            default: owner_of = S_VM2;
        endcase
    endfunction
endpackage

// File: rtl/rcr_arbiter.sv
// Module: rcr_arbiter
// Picks the single highest-priority reset pulse of this cycle.
// Assumes index 0 is the highest priority. Purely combinational.
module rcr_arbiter
    import rcr_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // Walk from the lowest priority to the highest so the highest request wins.
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
            end
        end
    end

    // Flag that some reset event is present this cycle.
    assign any = |req;

    always_comb begin
        a_onehot_grant_r5: assert ($onehot0(gnt));
    end
endmodule

// File: rtl/rcr_flags.sv
// Module: rcr_flags
// Holds the seven flags and applies the reset-event and bus-write rules for each bit.
// Assumes at most one grant is active. The storage has no reset: only a
// power-on grant clears it. rst_n is used by the assertions alone.
module rcr_flags
    import rcr_pkg::*;
#(
    parameter int N = SRC_N,
    parameter int W = FLG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] gnt,
    input  logic         any,
    input  logic         wr,
    input  logic [W-1:0] wd,
    output logic [W-1:0] flags
);
    logic         clr_all;
    logic [W-1:0] nxt;

    // A power-on or voltage monitor 0 event wipes the cause flags.
    assign clr_all = gnt[S_POR] | gnt[S_VM0];

    // Cold/warm start bit: power-on clears it, software can only set it.
    always_comb begin
        if (gnt[S_POR])      nxt[B_CWS] = 1'b0;
        else if (any)        nxt[B_CWS] = flags[B_CWS];
        else if (wr)         nxt[B_CWS] = flags[B_CWS] | wd[B_CWS];
        else                 nxt[B_CWS] = flags[B_CWS];
    end

    // Read-only cause flags: any event clears them, except that the owner sets its own.
    for (genvar b = B_RO_LO; b <= B_RO_HI; b++) begin : g_ro
        always_comb begin
            if (clr_all)               nxt[b] = 1'b0;
            else if (gnt[owner_of(b)]) nxt[b] = 1'b1;
            else if (any)              nxt[b] = 1'b0;
            else                       nxt[b] = flags[b];
        end
    end

    // Oscillator-stop bit: set by its own event, can only be cleared by software.
    always_comb begin
        if (clr_all)         nxt[B_OSC] = 1'b0;
        else if (gnt[S_OSC]) nxt[B_OSC] = 1'b1;
        else if (any)        nxt[B_OSC] = flags[B_OSC];
        else if (wr)         nxt[B_OSC] = flags[B_OSC] & wd[B_OSC];
        else                 nxt[B_OSC] = flags[B_OSC];
    end

    // Flag storage, updated in the edge that samples the event or the write.
    always_ff @(posedge clk) begin
        flags <= nxt;
    end

    p_por_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[S_POR] |=> (flags == '0));
    p_vm0_keeps_cws_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[S_VM0] |=> (flags[W-1:1] == '0) && (flags[B_CWS] == $past(flags[B_CWS])));
    p_one_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags[B_RO_HI:B_RO_LO]));
    p_cws_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[B_CWS] && !gnt[S_POR]) |=> flags[B_CWS]);
    p_osc_no_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[B_OSC] && !gnt[S_OSC]) |=> !flags[B_OSC]);
    p_ro_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !any) |=> $stable(flags[B_RO_HI:B_RO_LO]));
endmodule

// File: rtl/rst_cause_reg.sv
// Module: rst_cause_reg
// Top of the reset cause register: arbitrates the reset pulses, keeps the
// flags, and drives a registered read port. Assumes each pulse lasts one cycle
// and that the select comes from an external address decode.
module rst_cause_reg
    import rcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pls_por,
    input  logic             pls_pin,
    input  logic             pls_vm0,
    input  logic             pls_vm1,
    input  logic             pls_vm2,
    input  logic             pls_osc,
    input  logic             pls_wdt,
    input  logic             pls_sw,
    input  logic             sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    logic [SRC_N-1:0] req;
    logic [SRC_N-1:0] gnt;
    logic             any;
    logic [FLG_W-1:0] flags;

    // Gather the pulses in priority order.
    always_comb begin
        req        = '0;
        req[S_POR] = pls_por;
        req[S_VM0] = pls_vm0;
        req[S_VM1] = pls_vm1;
        req[S_VM2] = pls_vm2;
        req[S_OSC] = pls_osc;
        req[S_WDT] = pls_wdt;
        req[S_SW]  = pls_sw;
        req[S_PIN] = pls_pin;
    end

    rcr_arbiter #(.N(SRC_N)) u_arb (
        .req (req),
        .gnt (gnt),
        .any (any)
    );

    rcr_flags #(.N(SRC_N), .W(FLG_W)) u_flg (
        .clk   (clk),
        .rst_n (rst_n),
        .gnt   (gnt),
        .any   (any),
        .wr    (sel & wr_en),
        .wd    (wr_data[FLG_W-1:0]),
        .flags (flags)
    );

    // Registered read port; the reserved top bit is always driven as 0.
    always_ff @(posedge clk) begin
        if (!rst_n)              rd_data <= '0;
        else if (sel && !wr_en)  rd_data <= {1'b0, nxt_view()};
        else                     rd_data <= '0;
    end

    // Read view: the flag values after this edge.
    function automatic logic [FLG_W-1:0] nxt_view();
        return u_flg.nxt;
    endfunction

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !rd_data[REG_W-1]);
    p_idle_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (rd_data == '0));
endmodule

// File: tb/rst_cause_reg_tb.sv
// Bench: rst_cause_reg_tb
// Sweeps every pulse combination and every write byte against a byte model.
module rst_cause_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pls_por = 0, pls_pin = 0, pls_vm0 = 0, pls_vm1 = 0;
    logic       pls_vm2 = 0, pls_osc = 0, pls_wdt = 0, pls_sw = 0;
    logic       sel = 0, wr_en = 0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    rst_cause_reg u_dut (
        .clk(clk), .rst_n(rst_n),
        .pls_por(pls_por), .pls_pin(pls_pin), .pls_vm0(pls_vm0), .pls_vm1(pls_vm1),
        .pls_vm2(pls_vm2), .pls_osc(pls_osc), .pls_wdt(pls_wdt), .pls_sw(pls_sw),
        .sel(sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Bit order of the vector: por, vm0, vm1, vm2, osc, wdt, sw, pin.
    task automatic drive_pulses(input logic [7:0] p);
        pls_por = p[0]; pls_vm0 = p[1]; pls_vm1 = p[2]; pls_vm2 = p[3];
        pls_osc = p[4]; pls_wdt = p[5]; pls_sw = p[6]; pls_pin = p[7];
    endtask

    task automatic pulse(input logic [7:0] p);
        @(negedge clk); drive_pulses(p);
        @(negedge clk); drive_pulses(8'h00);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); sel = 1; wr_en = 1; wr_data = d;
        @(negedge clk); sel = 0; wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk); sel = 1; wr_en = 0;
        @(negedge clk); v = rd_data; sel = 0;
    endtask

    // Model from R3..R5: result byte of a pulse set applied to state s.
    function automatic logic [7:0] m_pulse(input logic [7:0] s, input logic [7:0] p);
        logic [7:0] base;
        base = {1'b0, s[6], 5'b0, s[0]};
        if (p[0])      return 8'h00;
        else if (p[1]) return {7'b0, s[0]};
        else if (p[2]) return base | 8'h10;
        else if (p[3]) return base | 8'h20;
        else if (p[4]) return base | 8'h40;
        else if (p[5]) return base | 8'h08;
        else if (p[6]) return base | 8'h04;
        else if (p[7]) return base | 8'h02;
        return s;
    endfunction

    // Model from R6..R8.
    function automatic logic [7:0] m_write(input logic [7:0] s, input logic [7:0] d);
        logic [7:0] r;
        r = s;
        r[0] = s[0] | d[0];
        r[6] = s[6] & d[6];
        return r;
    endfunction

    // Reach state 0x45: warm start, oscillator-stop seen, last cause software.
    task automatic prep45();
        pulse(8'h01); wr(8'h01); pulse(8'h10); pulse(8'h40);
    endtask

    initial begin
        logic [7:0] v;
        // R2 power-on while the system reset is low; R9 read path held at 0.
        pulse(8'h01);
        rd(v);
        check("R9 rd_data during rst_n low", v, 8'h00);
        @(negedge clk); rst_n = 1;
        rd(v);
        check("R2 power-on clears", v, 8'h00);
        @(negedge clk);
        check("R1 idle read is zero", rd_data, 8'h00);

        // R9: flags survive the system reset.
        prep45();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        rd(v);
        check("R9 flags kept over rst_n", v, 8'h45);

        // R3/R4/R5: every pulse combination from state 0x45.
        for (int p = 0; p < 256; p++) begin
            prep45();
            pulse(p[7:0]);
            rd(v);
            if (p == 2)             check("R3 vm0 keeps cold/warm", v, m_pulse(8'h45, p[7:0]));
            else if ($countones(p[7:0]) == 1) check("R4 single cause", v, m_pulse(8'h45, p[7:0]));
            else                    check("R5 priority", v, m_pulse(8'h45, p[7:0]));
        end

        // R6/R7/R8: every write byte from two states.
        for (int d = 0; d < 256; d++) begin
            prep45();
            wr(d[7:0]);
            rd(v);
            check("R7 R8 write rules from 45", v, m_write(8'h45, d[7:0]));
            pulse(8'h01); pulse(8'h80);
            wr(d[7:0]);
            rd(v);
            check("R6 R8 write rules from 02", v, m_write(8'h02, d[7:0]));
        end

        // R10: a write in the pulse cycle is discarded.
        prep45();
        @(negedge clk); drive_pulses(8'h20); sel = 1; wr_en = 1; wr_data = 8'h00;
        @(negedge clk); drive_pulses(8'h00); sel = 0; wr_en = 0;
        rd(v);
        check("R10 pulse beats write", v, 8'h49);
        pulse(8'h01);
        @(negedge clk); drive_pulses(8'h80); sel = 1; wr_en = 1; wr_data = 8'h01;
        @(negedge clk); drive_pulses(8'h00); sel = 0; wr_en = 0;
        rd(v);
        check("R10 set of bit 0 dropped", v, 8'h02);

        // R1: a read with the write strobe high returns 0.
        @(negedge clk); sel = 1; wr_en = 1; wr_data = 8'h00;
        @(negedge clk); v = rd_data; sel = 0; wr_en = 0;
        check("R1 write cycle reads zero", v, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule